// File: doc/BRIEF.md
# Trap Target and Vector Selector

This block decides how a processor takes an incoming trap and where execution resumes. It reads the current privilege state (hyperprivileged flag, reset-error-state flag, privileged flag), the current trap depth and the trap type. From these it picks one of five entry modes:

- reset/error-state entry;
- the error-state halt indication;
- a guest-watchdog escalation into hyperprivileged mode;
- a normal hyperprivileged entry;
- a normal privileged entry.

For every mode except the halt it forms the handler address and the address that follows it.

The three address bases are the privileged trap base, the hyperprivileged trap base, and a fixed reset-vector base at 0xFFF0000000. The trap type is scaled by 32 and merged into the low bits of the chosen base. The privileged table has a second half that is selected when the trap is nested.

A trap pipeline pulses `req_i` with the state and trap type valid in the same cycle. One cycle later the decision appears on the registered outputs. It stays there until the next request. The register save and the fetch redirect are done by neighbouring logic.

Top module: `trap_vector_sel`

## Requirements
- R1: After reset, `valid_o`=0, `mode_o`=0, `tt_o`=0, `pc_o`=0, `npc_o`=0 and `err_o`=0.
- R2: The outputs take the new decision on the first clock edge after a cycle with `req_i`=1. While `req_i`=0 they hold their values, whatever the other inputs do. `valid_o` becomes 1 after the first request.
- R3: If `red_i`=1, or `tl_i` equals MAX_TL-1, the mode is RED (`mode_o`=1) and `tt_o`=5. In that case `pc_o` = 0xFFF0000000 OR (5<<5) = 0xFFF00000A0. This rule wins over every other rule, including `tl_i`=MAX_TL.
- R4: If R3 does not apply and `tl_i` equals MAX_TL, the mode is ERROR (`mode_o`=2). Then `err_o`=1, `pc_o`=0, `npc_o`=0 and `tt_o` equals the incoming type. In every other mode `err_o`=0.
- R5: If neither R3 nor R4 applies, the current level is user (`hpriv_i`=0, `priv_i`=0) and `tl_i` > MAX_PTL, the mode is WDOG (`mode_o`=3) with `tt_o`=2. Then `pc_o` = (`htba_i` with bits 13:0 cleared) OR (2<<5).
- R6: Otherwise, the mode is HYP (`mode_o`=4) with `tt_o`=`tt_i` in either of two cases: the current level is privileged or hyperprivileged, or the level is user and `tt_i` >= 384. Then `pc_o` = (`htba_i` with bits 13:0 cleared) OR (`tt_i`<<5).
- R7: In all remaining cases the mode is PRIV (`mode_o`=5) with `tt_o`=`tt_i`. Then `pc_o` = (`tba_i` with bits 14:0 cleared) OR (bit 14 set when `tl_i`+1 > 1) OR (`tt_i`<<5).
- R8: In every mode except ERROR, `npc_o` = `pc_o` + 4.
- R9: `hpriv_i`=1 makes the current level hyperprivileged regardless of `priv_i`. With `hpriv_i`=0, `priv_i`=1 makes it privileged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Trap request, one cycle |
| hpriv_i | input | 1 | Current hyperprivileged flag |
| red_i | input | 1 | Current reset/error-state flag |
| priv_i | input | 1 | Current privileged flag |
| tl_i | input | TL_W | Current trap level |
| tt_i | input | 9 | Incoming trap type |
| tba_i | input | ADDR_W | Privileged trap base |
| htba_i | input | ADDR_W | Hyperprivileged trap base |
| valid_o | output | 1 | A decision has been made since reset |
| mode_o | output | 3 | Entry mode: 0 none, 1 RED, 2 ERROR, 3 WDOG, 4 HYP, 5 PRIV |
| tt_o | output | 9 | Effective trap type used for the vector |
| pc_o | output | ADDR_W | Handler address |
| npc_o | output | ADDR_W | Following address |
| err_o | output | 1 | Error-state indication |

## Verification
The properties check several rules on every cycle:

- outputs are held between requests;
- the reset-state flag forces RED entry with type 5;
- depth MAX_TL without the flag raises the error indication with a zero address;
- a user-level trap beyond MAX_PTL escalates to the watchdog;
- a hyperprivileged current level always yields HYP below the RED depth;
- the following address always sits four bytes past the handler address.

Only the bench scenarios, compared against an independent model, show the exact address composition. That covers merging the trap-base bits, the nested-table bit for the privileged table, and the type-384 boundary between privileged and hyperprivileged entry.

// File: rtl/trapvec_pkg.sv
package trapvec_pkg;

    localparam int TT_W         = 9;
    localparam int OFS_W        = 14;
    localparam int HYP_TT_MIN   = 384;
    localparam int RED_TT       = 5;
    localparam int WDOG_TT      = 2;
    localparam int INSN_BYTES   = 4;
    localparam logic [39:0] RED_BASE = 40'hFF_F000_0000;

    typedef enum logic [2:0] {
        TM_NONE  = 3'd0,
        TM_RED   = 3'd1,
        TM_ERROR = 3'd2,
        TM_WDOG  = 3'd3,
        TM_HYP   = 3'd4,
        TM_PRIV  = 3'd5
    } trap_mode_e;

    typedef enum logic [1:0] {
        LVL_USER = 2'd0,
        LVL_PRIV = 2'd1,
        LVL_HYP  = 2'd2
    } priv_lvl_e;

    typedef struct packed {
        trap_mode_e        mode;
        logic [TT_W-1:0]   vec_tt;
        logic              nested;
    } trap_dec_t;

    function automatic priv_lvl_e cur_level(input logic hpriv, input logic priv);
        if (hpriv)     return LVL_HYP;
        else if (priv) return LVL_PRIV;
        else           return LVL_USER;
    endfunction

    function automatic priv_lvl_e target_level(input priv_lvl_e cur);
        return (cur == LVL_USER) ? LVL_PRIV : LVL_HYP;
    endfunction

    function automatic logic [OFS_W-1:0] tt_offset(input logic [TT_W-1:0] tt);
        return {tt, 5'b0};
    endfunction

endpackage

// File: rtl/trap_class.sv
module trap_class
    import trapvec_pkg::*;
#(
    parameter int TL_W    = 3,
    parameter int MAX_TL  = 6,
    parameter int MAX_PTL = 2
) (
    input  logic            hpriv,
    input  logic            red,
    input  logic            priv,
    input  logic [TL_W-1:0] tl,
    input  logic [TT_W-1:0] tt,
    output trap_dec_t       dec
);
    localparam logic [TL_W-1:0] TL_RED  = TL_W'(MAX_TL - 1);
    localparam logic [TL_W-1:0] TL_HALT = TL_W'(MAX_TL);
    localparam logic [TL_W-1:0] TL_PLIM = TL_W'(MAX_PTL);
    localparam logic [TT_W-1:0] TT_HMIN = TT_W'(HYP_TT_MIN);

    priv_lvl_e tgt;

    always_comb begin
        tgt        = target_level(cur_level(hpriv, priv));
        dec.nested = (tl != '0);
        dec.vec_tt = tt;
        if (red || tl == TL_RED) begin
            dec.mode   = TM_RED;
            dec.vec_tt = TT_W'(RED_TT);
        end else if (tl == TL_HALT) begin
            dec.mode   = TM_ERROR;
        end else if (tl > TL_PLIM && tgt == LVL_PRIV) begin
            dec.mode   = TM_WDOG;
            dec.vec_tt = TT_W'(WDOG_TT);
        end else if (tgt == LVL_HYP || tt >= TT_HMIN) begin
            dec.mode   = TM_HYP;
        end else begin
            dec.mode   = TM_PRIV;
        end
    end
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen
    import trapvec_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  trap_dec_t         dec,
    input  logic [ADDR_W-1:0] tba,
    input  logic [ADDR_W-1:0] htba,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] npc
);
    localparam logic [ADDR_W-1:0] RED_BASE_W = ADDR_W'(RED_BASE);

    logic [ADDR_W-1:0] ofs;
    logic [ADDR_W-1:0] hyp_base;
    logic [ADDR_W-1:0] priv_base;

    assign ofs       = ADDR_W'(tt_offset(dec.vec_tt));
    assign hyp_base  = {htba[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    assign priv_base = {tba[ADDR_W-1:OFS_W+1], dec.nested, {OFS_W{1'b0}}};

    always_comb begin
        case (dec.mode)
            TM_RED:          pc = RED_BASE_W | ofs;
            TM_WDOG, TM_HYP: pc = hyp_base | ofs;
            TM_PRIV:         pc = priv_base | ofs;
            default:         pc = '0;
        endcase
        npc = (dec.mode == TM_ERROR) ? '0 : pc + ADDR_W'(INSN_BYTES);
    end
endmodule

// File: rtl/trap_vector_sel.sv
module trap_vector_sel
    import trapvec_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int TL_W    = 3,
    parameter int MAX_TL  = 6,
    parameter int MAX_PTL = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              hpriv_i,
    input  logic              red_i,
    input  logic              priv_i,
    input  logic [TL_W-1:0]   tl_i,
    input  logic [8:0]        tt_i,
    input  logic [ADDR_W-1:0] tba_i,
    input  logic [ADDR_W-1:0] htba_i,
    output logic              valid_o,
    output logic [2:0]        mode_o,
    output logic [8:0]        tt_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] npc_o,
    output logic              err_o
);
    trap_dec_t         dec;
    logic [ADDR_W-1:0] pc_d, npc_d;

    trap_class #(.TL_W(TL_W), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL)) u_class (
        .hpriv (hpriv_i),
        .red   (red_i),
        .priv  (priv_i),
        .tl    (tl_i),
        .tt    (tt_i),
        .dec   (dec)
    );

    trap_vec_gen #(.ADDR_W(ADDR_W)) u_vec (
        .dec  (dec),
        .tba  (tba_i),
        .htba (htba_i),
        .pc   (pc_d),
        .npc  (npc_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            mode_o  <= TM_NONE;
            tt_o    <= '0;
            pc_o    <= '0;
            npc_o   <= '0;
            err_o   <= 1'b0;
        end else if (req_i) begin
            valid_o <= 1'b1;
            mode_o  <= dec.mode;
            tt_o    <= dec.vec_tt;
            pc_o    <= pc_d;
            npc_o   <= npc_d;
            err_o   <= (dec.mode == TM_ERROR);
        end
    end
endmodule

// File: rtl/trap_vector_sel_chk.sv
module trap_vector_sel_chk #(
    parameter int ADDR_W  = 64,
    parameter int TL_W    = 3,
    parameter int MAX_TL  = 6,
    parameter int MAX_PTL = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_i,
    input logic              hpriv_i,
    input logic              red_i,
    input logic              priv_i,
    input logic [TL_W-1:0]   tl_i,
    input logic [8:0]        tt_i,
    input logic              valid_o,
    input logic [2:0]        mode_o,
    input logic [8:0]        tt_o,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] npc_o,
    input logic              err_o
);
    localparam logic [TL_W-1:0] C_RED  = TL_W'(MAX_TL - 1);
    localparam logic [TL_W-1:0] C_HALT = TL_W'(MAX_TL);
    localparam logic [TL_W-1:0] C_PLIM = TL_W'(MAX_PTL);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !req_i |=> ($stable(mode_o) && $stable(pc_o) && $stable(npc_o)
                    && $stable(tt_o) && $stable(err_o)));

    assert_red_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (req_i && red_i) |=> (mode_o == 3'd1 && tt_o == 9'd5 && !err_o));

    assert_halt_R4: assert property (@(posedge clk) disable iff (rst)
        (req_i && !red_i && tl_i == C_HALT) |=> (err_o && pc_o == '0 && mode_o == 3'd2));

    assert_wdog_R5: assert property (@(posedge clk) disable iff (rst)
        (req_i && !red_i && !hpriv_i && !priv_i && tl_i > C_PLIM && tl_i < C_RED)
        |=> (mode_o == 3'd3 && tt_o == 9'd2));

    assert_npc_step_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !err_o) |-> (npc_o == pc_o + ADDR_W'(4)));

    assert_hyp_level_R9: assert property (@(posedge clk) disable iff (rst)
        (req_i && hpriv_i && !red_i && tl_i < C_RED) |=> (mode_o == 3'd4));
endmodule

bind trap_vector_sel trap_vector_sel_chk #(
    .ADDR_W(ADDR_W), .TL_W(TL_W), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL)
) u_chk (.*);

// File: tb/trap_vector_sel_bench.sv
module trap_vector_sel_bench;
    localparam int AW = 64;
    localparam int TW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_i, hpriv_i, red_i, priv_i;
    logic [TW-1:0] tl_i;
    logic [8:0]    tt_i;
    logic [AW-1:0] tba_i, htba_i;
    logic          valid_o, err_o;
    logic [2:0]    mode_o;
    logic [8:0]    tt_o;
    logic [AW-1:0] pc_o, npc_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    trap_vector_sel u_trap_vector_sel (.*);

    // Expected decision built from the requirement text (MAX_TL 6, MAX_PTL 2)
    function automatic void model(
        input  logic hp, rd, pv,
        input  logic [TW-1:0] tl,
        input  logic [8:0] tt,
        input  logic [AW-1:0] tba, htba,
        output logic [2:0] m,
        output logic [8:0] et,
        output logic [AW-1:0] pc,
        output logic [AW-1:0] npc,
        output logic e);
        logic user;
        user = !hp && !pv;
        e  = 1'b0;
        et = tt;
        if (rd || tl == 3'd5) begin
            m = 3'd1; et = 9'd5; pc = 64'hFF_F000_00A0;
        end else if (tl == 3'd6) begin
            m = 3'd2; e = 1'b1; pc = '0;
        end else if (user && tl > 3'd2) begin
            m = 3'd3; et = 9'd2; pc = (htba & ~64'h3FFF) | 64'h40;
        end else if (!user || tt >= 9'd384) begin
            m = 3'd4; pc = (htba & ~64'h3FFF) | (64'(tt) << 5);
        end else begin
            m = 3'd5;
            pc = (tba & ~64'h7FFF) | ((tl != 0) ? 64'h4000 : 64'h0) | (64'(tt) << 5);
        end
        npc = e ? '0 : pc + 64'd4;
    endfunction

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic ok,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic hp, rd, pv, input logic [TW-1:0] tl,
                         input logic [8:0] tt, input logic [AW-1:0] tba, htba,
                         input string extra);
        logic [2:0] em; logic [8:0] et; logic [AW-1:0] ep, en; logic ee;
        model(hp, rd, pv, tl, tt, tba, htba, em, et, ep, en, ee);
        @(negedge clk);
        req_i = 1'b1; hpriv_i = hp; red_i = rd; priv_i = pv;
        tl_i = tl; tt_i = tt; tba_i = tba; htba_i = htba;
        @(negedge clk);
        req_i = 1'b0;
        check({req_of(em), extra, " mode"}, mode_o == em, 64'(mode_o), 64'(em));
        check({req_of(em), extra, " tt"}, tt_o == et, 64'(tt_o), 64'(et));
        check({req_of(em), extra, " pc"}, pc_o == ep, pc_o, ep);
        check({"R8", extra, " npc"}, npc_o == en, npc_o, en);
        check({"R4", extra, " err"}, err_o == ee, 64'(err_o), 64'(ee));
        check({"R2", extra, " valid"}, valid_o == 1'b1, 64'(valid_o), 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] hp_pc, hp_npc;
        void'($urandom(32'd20240611));
        rst = 1'b1; req_i = 0; hpriv_i = 0; red_i = 0; priv_i = 0;
        tl_i = '0; tt_i = '0; tba_i = '0; htba_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 valid", valid_o == 0, 64'(valid_o), 0);
        check("R1 mode", mode_o == 0, 64'(mode_o), 0);
        check("R1 pc", pc_o == 0 && npc_o == 0, pc_o, 0);
        check("R1 err/tt", err_o == 0 && tt_o == 0, 64'(tt_o), 0);

        // Directed corners
        apply(0, 1, 0, 3'd6, 9'h41, 64'h1234_5678_9ABC_DEF0, 64'hAAAA_BBBB_CCCC_DDDD, " red-over-halt");
        apply(1, 0, 1, 3'd5, 9'h10, 64'h0, 64'h0, " depth-red");
        apply(0, 0, 0, 3'd6, 9'h24, 64'hFFFF, 64'hFFFF, " halt");
        apply(0, 0, 0, 3'd3, 9'h80, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, " wdog");
        apply(0, 0, 0, 3'd2, 9'd383, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, " tt383");
        apply(0, 0, 0, 3'd2, 9'd384, 64'h0, 64'hFFFF_0000_FFFF_0000, " tt384");
        apply(0, 0, 0, 3'd0, 9'h1F, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, " tl0-table");
        apply(0, 0, 0, 3'd1, 9'h1F, 64'h0000_0000_0001_0000, 64'h0, " tl1-table");
        apply(0, 0, 1, 3'd4, 9'h11, 64'h0, 64'h8000_0000_0000_4000, " R9 priv-to-hyp");
        apply(1, 0, 0, 3'd0, 9'h11, 64'h0, 64'h8000_0000_0000_4000, " R9 hpriv-no-priv");
        hp_pc = pc_o; hp_npc = npc_o;
        apply(1, 0, 1, 3'd0, 9'h11, 64'h0, 64'h8000_0000_0000_4000, " R9 hpriv-and-priv");
        check("R9 same vector", pc_o == hp_pc && npc_o == hp_npc, pc_o, hp_pc);

        // R2: inputs change without a request; outputs must hold
        @(negedge clk);
        hpriv_i = 0; red_i = 1; tl_i = 3'd6; tt_i = 9'h1FF; htba_i = '1; tba_i = '1;
        repeat (3) @(negedge clk);
        check("R2 hold pc", pc_o == hp_pc, pc_o, hp_pc);
        check("R2 hold mode", mode_o == 3'd4, 64'(mode_o), 64'd4);

        // Random patterns
        for (int i = 0; i < 400; i++) begin
            logic [3:0] sel;
            sel = 4'($urandom_range(0, 15));
            apply(sel[0], (sel == 4'hF), sel[1], TW'($urandom_range(0, 6)),
                  9'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, " rand");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule